// File: doc/BRIEF.md
# Data Cache with Line Maintenance Commands

This block is a small direct-mapped write-back data cache. Its single command port takes ordinary word loads and stores, plus five line-level maintenance operations that software uses to steer the cache. Two of them are prefetch hints: touch, and touch-for-store. Clean writes a modified line back and keeps it. Flush writes a modified line back and drops it. Zero-allocate claims a line and clears it without reading memory. The target address of every command is the sum of two register operands presented with it.

Address translation happens outside the block. Its outcome arrives as one fault bit that travels with the command. The block decides from the operation whether a fault is reported to the requester or silently absorbed. Misses and write-backs travel over a word-serial memory port. Each word is a request held until it is acknowledged, and a whole line moves in ascending address order starting at the line-aligned address.

The command port accepts one operation at a time. It is busy from the cycle after acceptance until a one-cycle completion pulse, which carries read data and the fault flag.

Top module: `cmo_cache`

## Requirements
- R1: The target address of every command is cmd_ra + cmd_rb, modulo 2^32. The opcode values on cmd_op are: 0 load, 1 store, 2 touch, 3 touch-for-store, 4 clean, 5 flush, 6 zero-allocate.
- R2: A load or store that misses fetches the whole line. The fetch is a burst of 32-bit reads starting at the line-aligned address with the address rising by 4 on each word. The address is held until acknowledged. A load then returns the addressed word, and a hit causes no memory traffic.
- R3: A touch or touch-for-store to an absent line fetches that line, so a later load to it causes no memory traffic.
- R4: A touch or touch-for-store to a resident line completes with no memory traffic.
- R5: A touch or touch-for-store whose fault bit is set completes with rsp_fault low. It causes no memory traffic and allocates nothing.
- R6: Clean on a resident dirty line writes the line back as an ascending burst. The line stays resident and becomes clean.
- R7: Flush on a resident dirty line writes it back as an ascending burst and then invalidates it. Flush also invalidates a resident clean line.
- R8: Clean or flush on a clean or absent line completes with no memory traffic.
- R9: Load, store, clean, flush and zero-allocate with the fault bit set complete with rsp_fault high, cause no memory traffic and leave the cache unchanged.
- R10: Zero-allocate never reads memory. If a dirty victim of another address occupies the slot, it is written back first. The line then reads as zero and is dirty.
- R11: A command is accepted only while cmd_busy is low. cmd_busy is high from the cycle after acceptance until completion, and rsp_done is a single-cycle pulse. cmd_valid while busy is ignored.
- R12: After reset the block is idle with no request on the memory port, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code |
| cmd_ra | input | 32 | First address operand |
| cmd_rb | input | 32 | Second address operand |
| cmd_wdata | input | 32 | Store data |
| cmd_fault | input | 1 | Translation of the target address failed |
| cmd_busy | output | 1 | Command in progress |
| rsp_done | output | 1 | Completion pulse |
| rsp_fault | output | 1 | Fault reported, valid with rsp_done |
| rsp_rdata | output | 32 | Load data, valid with rsp_done |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The hardest state to reach is a zero-allocate or a fill that must first evict a dirty line belonging to a different address in the same slot. Reaching it takes a deliberate sequence through the ports: a load to fill the slot, a store to dirty it, then a command to a second address chosen to share the index. The stimulus builds exactly that chain and then checks the write-back burst, the absence of reads, and the memory contents. Invalidation by flush cannot be seen directly either. It is revealed by a following load that must produce a full fill burst.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    localparam int WORD_BYTES = 4;

    typedef enum logic [2:0] {
        OP_LOAD    = 3'd0,
        OP_STORE   = 3'd1,
        OP_TOUCH   = 3'd2,
        OP_TOUCH_W = 3'd3,
        OP_CLEAN   = 3'd4,
        OP_FLUSH   = 3'd5,
        OP_ZERO    = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_WB,
        S_FILL,
        S_ZERO,
        S_ACT
    } state_e;

    // prefetch hints swallow translation faults
    function automatic logic is_hint(input op_e op);
        return (op == OP_TOUCH) || (op == OP_TOUCH_W);
    endfunction

    // where to go once a write-back burst has drained
    function automatic state_e after_wb(input op_e op);
        case (op)
            OP_CLEAN, OP_FLUSH: return S_ACT;
            OP_ZERO:            return S_ZERO;
            default:            return S_FILL;
        endcase
    endfunction

endpackage

// File: rtl/cmo_tag_store.sv
module cmo_tag_store #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             we,
    input  logic             w_valid,
    input  logic             w_dirty,
    input  logic [TAG_W-1:0] w_tag,
    output logic             r_valid,
    output logic             r_dirty,
    output logic [TAG_W-1:0] r_tag
);

    logic             valid_a [NUM_LINES];
    logic             dirty_a [NUM_LINES];
    logic [TAG_W-1:0] tag_a   [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_a[g] <= 1'b0;
                dirty_a[g] <= 1'b0;
                tag_a[g]   <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                valid_a[g] <= w_valid;
                dirty_a[g] <= w_dirty;
                tag_a[g]   <= w_tag;
            end
        end
    end

    assign r_valid = valid_a[idx];
    assign r_dirty = dirty_a[idx];
    assign r_tag   = tag_a[idx];

endmodule

// File: rtl/cmo_data_store.sv
module cmo_data_store #(
    parameter int DEPTH  = 64,
    parameter int AW     = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/cmo_cache.sv
module cmo_cache
    import cmo_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_ra,
    input  logic [ADDR_W-1:0] cmd_rb,
    input  logic [31:0]       cmd_wdata,
    input  logic              cmd_fault,
    output logic              cmd_busy,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [31:0]       rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata
);

    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int WORD_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int DA_W   = IDX_W + WORD_W;
    localparam logic [WORD_W-1:0] LAST_W = WORD_W'(WORDS - 1);

    state_e              state, state_d;
    op_e                 op_q;
    logic [ADDR_W-1:0]   ea_q;
    logic [31:0]         wdata_q;
    logic                fault_q;
    logic [WORD_W-1:0]   wcnt, wcnt_d;
    logic                done_d, fault_d;
    logic [31:0]         rdata_d;

    logic [IDX_W-1:0]    idx;
    logic [TAG_W-1:0]    tagq;
    logic [WORD_W-1:0]   woff;
    logic                unused_lo;

    logic                t_valid, t_dirty;
    logic [TAG_W-1:0]    t_tag;
    logic                tw_en, tw_valid, tw_dirty;
    logic [TAG_W-1:0]    tw_tag;
    logic                hit;

    logic                dw_en;
    logic [DA_W-1:0]     dw_addr, dr_addr;
    logic [31:0]         dw_data, dr_data;

    assign idx       = ea_q[OFF_W +: IDX_W];
    assign tagq      = ea_q[ADDR_W-1 -: TAG_W];
    assign woff      = ea_q[2 +: WORD_W];
    assign unused_lo = ^ea_q[1:0];
    assign hit       = t_valid && (t_tag == tagq);

    cmo_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk     (clk),
        .rst     (rst),
        .idx     (idx),
        .we      (tw_en),
        .w_valid (tw_valid),
        .w_dirty (tw_dirty),
        .w_tag   (tw_tag),
        .r_valid (t_valid),
        .r_dirty (t_dirty),
        .r_tag   (t_tag)
    );

    cmo_data_store #(
        .DEPTH (NUM_LINES * WORDS),
        .AW    (DA_W)
    ) u_data (
        .clk   (clk),
        .we    (dw_en),
        .waddr (dw_addr),
        .wdata (dw_data),
        .raddr (dr_addr),
        .rdata (dr_data)
    );

    assign dr_addr   = (state == S_WB) ? {idx, wcnt} : {idx, woff};
    assign cmd_busy  = (state != S_IDLE);
    assign mem_req   = (state == S_WB) || (state == S_FILL);
    assign mem_we    = (state == S_WB);
    assign mem_addr  = (state == S_WB) ? {t_tag, idx, wcnt, 2'b00}
                                       : {tagq,  idx, wcnt, 2'b00};
    assign mem_wdata = dr_data;

    always_comb begin
        state_d  = state;
        wcnt_d   = wcnt;
        done_d   = 1'b0;
        fault_d  = 1'b0;
        rdata_d  = rsp_rdata;
        tw_en    = 1'b0;
        tw_valid = t_valid;
        tw_dirty = t_dirty;
        tw_tag   = t_tag;
        dw_en    = 1'b0;
        dw_addr  = {idx, wcnt};
        dw_data  = '0;
        case (state)
            S_IDLE: begin
                if (cmd_valid) state_d = S_LOOK;
            end
            S_LOOK: begin
                wcnt_d = '0;
                if (fault_q) begin
                    done_d  = 1'b1;
                    fault_d = !is_hint(op_q);
                    state_d = S_IDLE;
                end else begin
                    case (op_q)
                        OP_CLEAN, OP_FLUSH:
                            state_d = (hit && t_dirty) ? S_WB : S_ACT;
                        OP_ZERO:
                            state_d = (!hit && t_valid && t_dirty) ? S_WB : S_ZERO;
                        default:
                            state_d = hit ? S_ACT
                                    : (t_valid && t_dirty) ? S_WB : S_FILL;
                    endcase
                end
            end
            S_WB: begin
                if (mem_ack) begin
                    wcnt_d = wcnt + 1'b1;
                    if (wcnt == LAST_W) state_d = after_wb(op_q);
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    dw_en   = 1'b1;
                    dw_data = mem_rdata;
                    wcnt_d  = wcnt + 1'b1;
                    if (wcnt == LAST_W) begin
                        tw_en    = 1'b1;
                        tw_valid = 1'b1;
                        tw_dirty = 1'b0;
                        tw_tag   = tagq;
                        state_d  = S_ACT;
                    end
                end
            end
            S_ZERO: begin
                dw_en  = 1'b1;
                wcnt_d = wcnt + 1'b1;
                if (wcnt == LAST_W) begin
                    tw_en    = 1'b1;
                    tw_valid = 1'b1;
                    tw_dirty = 1'b1;
                    tw_tag   = tagq;
                    state_d  = S_ACT;
                end
            end
            S_ACT: begin
                done_d  = 1'b1;
                state_d = S_IDLE;
                case (op_q)
                    OP_LOAD: rdata_d = dr_data;
                    OP_STORE: begin
                        dw_en    = 1'b1;
                        dw_addr  = {idx, woff};
                        dw_data  = wdata_q;
                        tw_en    = 1'b1;
                        tw_dirty = 1'b1;
                    end
                    OP_CLEAN: begin
                        if (hit) begin
                            tw_en    = 1'b1;
                            tw_dirty = 1'b0;
                        end
                    end
                    OP_FLUSH: begin
                        if (hit) begin
                            tw_en    = 1'b1;
                            tw_valid = 1'b0;
                            tw_dirty = 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            op_q      <= OP_LOAD;
            ea_q      <= '0;
            wdata_q   <= '0;
            fault_q   <= 1'b0;
            wcnt      <= '0;
            rsp_done  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            state     <= state_d;
            wcnt      <= wcnt_d;
            rsp_done  <= done_d;
            rsp_fault <= fault_d;
            rsp_rdata <= rdata_d;
            if (state == S_IDLE && cmd_valid) begin
                op_q    <= op_e'(cmd_op);
                ea_q    <= cmd_ra + cmd_rb;
                wdata_q <= cmd_wdata;
                fault_q <= cmd_fault;
            end
        end
    end

endmodule

// File: rtl/cmo_cache_chk.sv
module cmo_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cmd_busy,
    input logic              rsp_done,
    input logic              rsp_fault,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    logic hint_pend, zero_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            hint_pend <= 1'b0;
            zero_pend <= 1'b0;
        end else if (cmd_valid && !cmd_busy) begin
            hint_pend <= (cmd_op == 3'd2) || (cmd_op == 3'd3);
            zero_pend <= (cmd_op == 3'd6);
        end else if (rsp_done) begin
            hint_pend <= 1'b0;
            zero_pend <= 1'b0;
        end
    end

    // R11
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cmd_busy);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_busy) |=> cmd_busy);

    // R9
    fault_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_done);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    hint_nofault_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && hint_pend) |-> !rsp_fault);

    // R10
    zero_noread_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_pend && mem_req) |-> mem_we);

endmodule

bind cmo_cache cmo_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_busy  (cmd_busy),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/cmo_cache_test.sv
`timescale 1ns/1ps
module cmo_cache_test;

    localparam logic [2:0] LD = 3'd0, ST = 3'd1, TCH = 3'd2, TCHW = 3'd3,
                           CLN = 3'd4, FLS = 3'd5, ZRO = 3'd6;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_ra, cmd_rb, cmd_wdata;
    logic        cmd_fault;
    logic        cmd_busy, rsp_done, rsp_fault;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0] mem_arr [0:1023];
    logic [31:0] rd_log [0:15];
    logic [31:0] wr_log [0:15];
    int rd_cnt, wr_cnt;

    logic [31:0] got_data;
    logic        got_fault;

    always #2 clk = ~clk;

    cmo_cache uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_wdata(cmd_wdata),
        .cmd_fault(cmd_fault), .cmd_busy(cmd_busy), .rsp_done(rsp_done),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // word-serial memory: acknowledges one cycle after a request appears
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem_arr[mem_addr[11:2]] <= mem_wdata;
                if (wr_cnt < 16) wr_log[wr_cnt] = mem_addr;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rdata <= mem_arr[mem_addr[11:2]];
                if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
                rd_cnt = rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_burst(input string tag, input bit wr, input logic [31:0] base,
                             input int n);
        bit ok = 1'b1;
        int cnt = wr ? wr_cnt : rd_cnt;
        if (cnt != n) ok = 1'b0;
        for (int k = 0; k < n && k < 16; k++) begin
            if ((wr ? wr_log[k] : rd_log[k]) !== base + 32'(4 * k)) ok = 1'b0;
        end
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d words expected=%0d words from %h", tag, cnt, n, base);
        end
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, 32'(rd_cnt + wr_cnt), 32'd0);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!rsp_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 2000) chk("R11 completion timeout", 32'd0, 32'd1);
        got_data  = rsp_rdata;
        got_fault = rsp_fault;
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] ra, input logic [31:0] rb,
                         input logic [31:0] wd, input bit flt);
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_ra    = ra;
        cmd_rb    = rb;
        cmd_wdata = wd;
        cmd_fault = flt;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_fault = 1'b0;
        wait_done();
    endtask

    task automatic t_reset();
        chk("R12 busy after reset", {31'd0, cmd_busy}, 32'd0);
        chk("R12 done after reset", {31'd0, rsp_done}, 32'd0);
        chk("R12 mem_req after reset", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_load_store();
        do_op(LD, 32'h40, 32'h4, 0, 0);
        chk_burst("R2 R12 load miss fill", 0, 32'h40, 8);
        chk("R1 load data split operands", got_data, 32'hA000_0011);
        do_op(LD, 32'h48, 32'h0, 0, 0);
        chk_quiet("R2 load hit traffic");
        chk("R2 load hit data", got_data, 32'hA000_0012);
        do_op(ST, 32'h100, 32'hFFFF_FF44, 32'h1234_5678, 0);
        chk_quiet("R1 R2 store hit wrapped sum");
        do_op(LD, 32'h0, 32'h44, 0, 0);
        chk("R1 store visible", got_data, 32'h1234_5678);
    endtask

    task automatic t_clean();
        do_op(CLN, 32'h20, 32'h20, 0, 0);
        chk_burst("R6 clean write-back", 1, 32'h40, 8);
        chk("R6 memory updated", mem_arr[32'h11], 32'h1234_5678);
        do_op(CLN, 32'h40, 32'h0, 0, 0);
        chk_quiet("R6 R8 second clean quiet");
        do_op(LD, 32'h44, 32'h0, 0, 0);
        chk_quiet("R6 line kept after clean");
    endtask

    task automatic t_touch();
        do_op(TCH, 32'h80, 32'h0, 0, 0);
        chk_burst("R3 touch fills absent line", 0, 32'h80, 8);
        do_op(TCH, 32'h84, 32'h0, 0, 0);
        chk_quiet("R4 touch resident");
        do_op(TCHW, 32'h88, 32'h0, 0, 0);
        chk_quiet("R4 touch-for-store resident");
        do_op(LD, 32'h84, 32'h0, 0, 0);
        chk_quiet("R3 load after touch");
        chk("R3 load data after touch", got_data, 32'hA000_0021);
    endtask

    task automatic t_touch_fault();
        do_op(TCH, 32'hC0, 32'h0, 0, 1);
        chk("R5 touch fault hidden", {31'd0, got_fault}, 32'd0);
        chk_quiet("R5 touch fault quiet");
        do_op(TCHW, 32'hC0, 32'h0, 0, 1);
        chk("R5 touch-for-store fault hidden", {31'd0, got_fault}, 32'd0);
        do_op(LD, 32'hC0, 32'h0, 0, 0);
        chk_burst("R5 nothing allocated", 0, 32'hC0, 8);
    endtask

    task automatic t_flush();
        do_op(ST, 32'h84, 32'h0, 32'hCAFE_0001, 0);
        do_op(FLS, 32'h80, 32'h0, 0, 0);
        chk_burst("R7 flush write-back", 1, 32'h80, 8);
        chk("R7 memory updated", mem_arr[32'h21], 32'hCAFE_0001);
        do_op(LD, 32'h84, 32'h0, 0, 0);
        chk_burst("R7 invalidated, refetch", 0, 32'h80, 8);
        chk("R7 refetched data", got_data, 32'hCAFE_0001);
        do_op(FLS, 32'h84, 32'h0, 0, 0);
        chk_quiet("R8 flush clean line quiet");
        do_op(LD, 32'h84, 32'h0, 0, 0);
        chk_burst("R7 clean line invalidated", 0, 32'h80, 8);
        do_op(FLS, 32'h200, 32'h0, 0, 0);
        chk_quiet("R8 flush absent quiet");
        do_op(CLN, 32'h300, 32'h0, 0, 0);
        chk_quiet("R8 clean absent quiet");
    endtask

    task automatic t_faults();
        do_op(LD, 32'h44, 32'h0, 0, 1);
        chk("R9 load fault", {31'd0, got_fault}, 32'd1);
        chk_quiet("R9 load fault quiet");
        do_op(ST, 32'h44, 32'h0, 32'hDEAD_DEAD, 1);
        chk("R9 store fault", {31'd0, got_fault}, 32'd1);
        do_op(CLN, 32'h40, 32'h0, 0, 1);
        chk("R9 clean fault", {31'd0, got_fault}, 32'd1);
        do_op(FLS, 32'h40, 32'h0, 0, 1);
        chk("R9 flush fault", {31'd0, got_fault}, 32'd1);
        do_op(ZRO, 32'h40, 32'h0, 0, 1);
        chk("R9 zero fault", {31'd0, got_fault}, 32'd1);
        chk_quiet("R9 zero fault quiet");
        do_op(LD, 32'h44, 32'h0, 0, 0);
        chk_quiet("R9 line still resident");
        chk("R9 line unchanged", got_data, 32'h1234_5678);
    endtask

    task automatic t_zero();
        do_op(ZRO, 32'h140, 32'h0, 0, 0);
        chk_quiet("R10 zero over clean victim");
        do_op(LD, 32'h144, 32'h0, 0, 0);
        chk_quiet("R10 zeroed line resident");
        chk("R10 zeroed data", got_data, 32'h0);
        do_op(FLS, 32'h140, 32'h0, 0, 0);
        chk_burst("R10 zeroed line dirty", 1, 32'h140, 8);
        chk("R10 zeros in memory", mem_arr[32'h51], 32'h0);
        do_op(LD, 32'h1C0, 32'h0, 0, 0);
        do_op(ST, 32'h1C4, 32'h0, 32'h0000_BEEF, 0);
        do_op(ZRO, 32'h2C0, 32'h0, 0, 0);
        chk_burst("R10 dirty victim written back", 1, 32'h1C0, 8);
        chk("R10 no memory read", 32'(rd_cnt), 32'd0);
        chk("R10 victim data", mem_arr[32'h71], 32'h0000_BEEF);
        do_op(LD, 32'h2C8, 32'h0, 0, 0);
        chk("R10 new line zero", got_data, 32'h0);
    endtask

    task automatic t_busy();
        @(negedge clk);
        rd_cnt = 0;
        wr_cnt = 0;
        cmd_valid = 1'b1;
        cmd_op    = LD;
        cmd_ra    = 32'h300;
        cmd_rb    = 32'h0;
        cmd_fault = 1'b0;
        @(negedge clk);
        chk("R11 busy after accept", {31'd0, cmd_busy}, 32'd1);
        cmd_op    = ST;
        cmd_ra    = 32'h304;
        cmd_wdata = 32'h5555_5555;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done();
        @(negedge clk);
        chk("R11 done is one pulse", {31'd0, rsp_done}, 32'd0);
        chk("R11 idle after done", {31'd0, cmd_busy}, 32'd0);
        do_op(LD, 32'h304, 32'h0, 0, 0);
        chk_quiet("R11 hit after busy load");
        chk("R11 store while busy ignored", got_data, 32'hA000_00C1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem_arr[i] = 32'hA000_0000 + 32'(i);
        rd_cnt = 0;
        wr_cnt = 0;
        mem_rdata = '0;
        rst = 1'b1;
        cmd_valid = 1'b0;
        cmd_op = LD;
        cmd_ra = '0;
        cmd_rb = '0;
        cmd_wdata = '0;
        cmd_fault = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_store();
        t_clean();
        t_touch();
        t_touch_fault();
        t_flush();
        t_faults();
        t_zero();
        t_busy();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule